// File: doc/BRIEF.md
# Virtual Address Translation Buffer with Page-Table Refill

This block translates 32-bit byte virtual addresses into 30-bit physical addresses. Pages are 4 KB, so the low 12 address bits go through unchanged and the upper 20 bits are the virtual page number (VPN). Recent translations are held in a small fully associative buffer that is searched in one cycle. On a hit the physical address comes back the next cycle and memory is not touched.

On a miss the block fetches one 32-bit page-table entry (PTE) from a flat table in memory. The table's address comes from a base register. The block installs the entry and then completes the translation. Each translation carries a read-only flag and a dirty flag. The block reports a page fault when the entry is invalid and a protection fault when a store hits a read-only page. A store to a writable page marks that page dirty.

The base register and the flush control take effect only in supervisor mode. A user-mode attempt changes nothing and pulses an error output.

Top module: `vxlate_tlb`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid`, `fault_page`, `fault_prot`, `priv_err` and `mem_req_valid` are 0. The buffer is empty, so the first access misses.
- R2: A request accepted while `req_valid` and `req_ready` are both high that hits gives `resp_valid` in the next cycle. `resp_paddr` equals {stored physical page number, vaddr[11:0]}, and no memory read is issued.
- R3: A miss raises `mem_req_valid` for exactly one cycle, starting the cycle after acceptance, with `mem_req_addr` = base + VPN*4. `req_ready` stays low until the response.
- R4: The PTE layout is: bit 31 valid, bit 30 read-only, bit 29 dirty, bits 17:0 physical page number, and bits 28:18 ignored. A valid PTE is installed, and the response follows in the cycle after `mem_rsp_valid`. Later accesses to that page hit.
- R5: An invalid PTE gives `resp_valid` together with `fault_page` and is not installed, so the same page misses again.
- R6: A store to a read-only page gives `fault_prot` with the response and leaves the page clean. A load from a read-only page completes without a fault.
- R7: `resp_dirty` reports the page's dirty flag after the access. A store to a writable page sets the flag, and the flag stays set for later loads. A fetched PTE with its dirty bit set installs as dirty.
- R8: On refill, the lowest-numbered empty entry is used first. When all 8 entries are full, the block evicts in round-robin order starting at entry 0, and the pointer advances after each eviction.
- R9: `ctl_base_we` loads the base register from `ctl_base_wdata` only when `priv_sup` is 1. Otherwise the register is unchanged and `priv_err` pulses in the next cycle.
- R10: `ctl_flush` with `priv_sup` set empties the whole buffer in one cycle. Without `priv_sup` the flush is ignored and `priv_err` pulses in the next cycle.
- R11: A `mem_rsp_valid` pulse while no refill is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual byte address |
| req_store | input | 1 | 1 for store, 0 for load |
| req_ready | output | 1 | Block can accept a request |
| resp_valid | output | 1 | Translation result valid |
| resp_paddr | output | 30 | Physical byte address |
| resp_dirty | output | 1 | Page dirty flag after the access |
| fault_page | output | 1 | Page not present |
| fault_prot | output | 1 | Store to read-only page |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_addr | output | 32 | Page-table entry address |
| mem_rsp_valid | input | 1 | Page-table read data valid |
| mem_rsp_data | input | 32 | Page-table entry |
| priv_sup | input | 1 | Supervisor mode |
| ctl_base_we | input | 1 | Write page-table base |
| ctl_base_wdata | input | 32 | New base value |
| ctl_flush | input | 1 | Invalidate all entries |
| priv_err | output | 1 | Privileged control attempted in user mode |

## Verification
A wrong tag or valid bit shows up on the very next access to the affected page. A hit that should have missed gives a response one cycle after acceptance with no `mem_req_valid`. A miss that should have hit gives a read request instead of a response. A corrupted replacement pointer stays hidden until the buffer is full, and then shows up as the wrong page missing after an eviction. A lost dirty or read-only flag appears on `resp_dirty` or `fault_prot` at the next access to that page. A wrong base register appears on `mem_req_addr` at the next miss.

// File: rtl/vxlate_pkg.sv
package vxlate_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_WAIT = 2'd2
    } walk_e;
endpackage

// File: rtl/vxlate_match.sv
module vxlate_match #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int IDX_W   = 3
) (
    input  logic [ENTRIES-1:0]            vld,
    input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]              vpn,
    output logic                          hit,
    output logic [IDX_W-1:0]              idx
);
    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = vld[g] && (tags[g] == vpn);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end

    assign hit = |eq;
endmodule

// File: rtl/vxlate_victim.sv
module vxlate_victim #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic [ENTRIES-1:0] vld,
    input  logic [IDX_W-1:0]   rr,
    output logic [IDX_W-1:0]   idx,
    output logic               from_free
);
    always_comb begin
        idx = rr;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) idx = IDX_W'(i);
        end
    end

    assign from_free = ~&vld;
endmodule

// File: rtl/vxlate_tlb.sv
module vxlate_tlb
    import vxlate_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PPN_W     = 18,
    parameter int ENTRIES   = 8,
    parameter int PTE_W     = 32,
    parameter int MA_W      = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [VA_W-1:0]           req_vaddr,
    input  logic                      req_store,
    output logic                      req_ready,
    output logic                      resp_valid,
    output logic [PPN_W+PAGE_BITS-1:0] resp_paddr,
    output logic                      resp_dirty,
    output logic                      fault_page,
    output logic                      fault_prot,
    output logic                      mem_req_valid,
    output logic [MA_W-1:0]           mem_req_addr,
    input  logic                      mem_rsp_valid,
    input  logic [PTE_W-1:0]          mem_rsp_data,
    input  logic                      priv_sup,
    input  logic                      ctl_base_we,
    input  logic [MA_W-1:0]           ctl_base_wdata,
    input  logic                      ctl_flush,
    output logic                      priv_err
);
    localparam int VPN_W  = VA_W - PAGE_BITS;
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int PA_W   = PPN_W + PAGE_BITS;
    localparam int PTE_SH = $clog2(PTE_W / 8);
    localparam int B_V    = PTE_W - 1;
    localparam int B_RO   = PTE_W - 2;
    localparam int B_D    = PTE_W - 3;

    typedef struct packed {
        walk_e                          st;
        logic [VPN_W-1:0]               vpn;
        logic [PAGE_BITS-1:0]           off;
        logic                           store;
        logic [MA_W-1:0]                base;
        logic [IDX_W-1:0]               rr;
        logic [ENTRIES-1:0]             v;
        logic [ENTRIES-1:0]             ro;
        logic [ENTRIES-1:0]             dy;
        logic [ENTRIES-1:0][VPN_W-1:0]  tag;
        logic [ENTRIES-1:0][PPN_W-1:0]  ppn;
        logic                           rsp_v;
        logic [PA_W-1:0]                rsp_pa;
        logic                           rsp_dy;
        logic                           f_pg;
        logic                           f_pr;
        logic                           p_err;
    } state_t;

    state_t r_d, r_q;

    logic [VPN_W-1:0] in_vpn;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] vic_idx;
    logic             vic_free;
    logic             unused_pte_mid;

    assign in_vpn         = req_vaddr[VA_W-1:PAGE_BITS];
    assign unused_pte_mid = ^mem_rsp_data[B_D-1:PPN_W];

    vxlate_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_match (
        .vld  (r_q.v),
        .tags (r_q.tag),
        .vpn  (in_vpn),
        .hit  (hit),
        .idx  (hit_idx)
    );

    vxlate_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .vld       (r_q.v),
        .rr        (r_q.rr),
        .idx       (vic_idx),
        .from_free (vic_free)
    );

    always_comb begin
        logic ctl_any;
        logic pte_ro;
        logic flush_ok;
        r_d       = r_q;
        r_d.rsp_v = 1'b0;
        r_d.f_pg  = 1'b0;
        r_d.f_pr  = 1'b0;
        r_d.p_err = 1'b0;
        ctl_any   = ctl_base_we || ctl_flush;
        flush_ok  = ctl_flush && priv_sup;
        pte_ro    = mem_rsp_data[B_RO];

        // privileged control
        if (ctl_any && !priv_sup) begin
            r_d.p_err = 1'b1;
        end else if (ctl_base_we) begin
            r_d.base = ctl_base_wdata;
        end

        unique case (r_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    r_d.vpn   = in_vpn;
                    r_d.off   = req_vaddr[PAGE_BITS-1:0];
                    r_d.store = req_store;
                    if (hit) begin
                        r_d.rsp_v  = 1'b1;
                        r_d.rsp_pa = {r_q.ppn[hit_idx], req_vaddr[PAGE_BITS-1:0]};
                        r_d.rsp_dy = r_q.dy[hit_idx];
                        if (req_store && r_q.ro[hit_idx]) begin
                            r_d.f_pr = 1'b1;
                        end else if (req_store) begin
                            r_d.dy[hit_idx] = 1'b1;
                            r_d.rsp_dy      = 1'b1;
                        end
                    end else begin
                        r_d.st = S_REQ;
                    end
                end
            end
            S_REQ: begin
                r_d.st = S_WAIT;
            end
            S_WAIT: begin
                if (mem_rsp_valid) begin
                    r_d.st    = S_IDLE;
                    r_d.rsp_v = 1'b1;
                    if (!mem_rsp_data[B_V]) begin
                        r_d.f_pg   = 1'b1;
                        r_d.rsp_pa = '0;
                        r_d.rsp_dy = 1'b0;
                    end else begin
                        r_d.v[vic_idx]   = 1'b1;
                        r_d.tag[vic_idx] = r_q.vpn;
                        r_d.ppn[vic_idx] = mem_rsp_data[PPN_W-1:0];
                        r_d.ro[vic_idx]  = pte_ro;
                        r_d.dy[vic_idx]  = mem_rsp_data[B_D] || (r_q.store && !pte_ro);
                        r_d.rsp_dy       = mem_rsp_data[B_D] || (r_q.store && !pte_ro);
                        r_d.rsp_pa       = {mem_rsp_data[PPN_W-1:0], r_q.off};
                        r_d.f_pr         = r_q.store && pte_ro;
                        if (!vic_free) begin
                            r_d.rr = (r_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : r_q.rr + 1'b1;
                        end
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase

        // a permitted flush overrides any install in the same cycle
        if (flush_ok) begin
            r_d.v = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.st == S_IDLE);
    assign mem_req_valid = (r_q.st == S_REQ);
    assign mem_req_addr  = r_q.base + (MA_W'(r_q.vpn) << PTE_SH);
    assign resp_valid    = r_q.rsp_v;
    assign resp_paddr    = r_q.rsp_pa;
    assign resp_dirty    = r_q.rsp_dy;
    assign fault_page    = r_q.f_pg;
    assign fault_prot    = r_q.f_pr;
    assign priv_err      = r_q.p_err;
endmodule

// File: rtl/vxlate_tlb_chk.sv
module vxlate_tlb_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_store,
    input logic req_ready,
    input logic resp_valid,
    input logic resp_dirty,
    input logic fault_page,
    input logic fault_prot,
    input logic mem_req_valid,
    input logic priv_sup,
    input logic ctl_base_we,
    input logic ctl_flush,
    input logic priv_err
);
    // R3
    refill_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> $past(req_valid && req_ready));

    // R3
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R2
    resp_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> req_ready);

    // R5
    page_fault_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_page |-> (resp_valid && !fault_prot));

    // R6
    prot_with_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_prot |-> resp_valid);

    // R9
    priv_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_err |-> $past((ctl_base_we || ctl_flush) && !priv_sup));

    // R10
    flush_forces_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && $past(ctl_flush && priv_sup)) |=> mem_req_valid);

    // R7
    store_hit_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_store) |=> (!resp_valid || fault_prot || resp_dirty));
endmodule

bind vxlate_tlb vxlate_tlb_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_store     (req_store),
    .req_ready     (req_ready),
    .resp_valid    (resp_valid),
    .resp_dirty    (resp_dirty),
    .fault_page    (fault_page),
    .fault_prot    (fault_prot),
    .mem_req_valid (mem_req_valid),
    .priv_sup      (priv_sup),
    .ctl_base_we   (ctl_base_we),
    .ctl_flush     (ctl_flush),
    .priv_err      (priv_err)
);

// File: tb/vxlate_tlb_tb.sv
`timescale 1ns/1ps
module vxlate_tlb_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_store = 1'b0;
    logic        req_ready;
    logic        resp_valid;
    logic [29:0] resp_paddr;
    logic        resp_dirty;
    logic        fault_page;
    logic        fault_prot;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        priv_sup = 1'b0;
    logic        ctl_base_we = 1'b0;
    logic [31:0] ctl_base_wdata = '0;
    logic        ctl_flush = 1'b0;
    logic        priv_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    vxlate_tlb u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_store(req_store),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_dirty(resp_dirty), .fault_page(fault_page), .fault_prot(fault_prot),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .priv_sup(priv_sup), .ctl_base_we(ctl_base_we), .ctl_base_wdata(ctl_base_wdata),
        .ctl_flush(ctl_flush), .priv_err(priv_err)
    );

    typedef struct packed {
        logic [31:0] va;
        logic        st;
        logic [31:0] pte;
        logic        miss;
        logic [29:0] pa;
        logic        dy;
        logic        fpg;
        logic        fpr;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_1234, 1'b0, 32'h8FFC_0ABC, 1'b1, 30'h00AB_C234, 1'b0, 1'b0, 1'b0}, // R3 R4
        '{32'h0000_1FF0, 1'b0, 32'h0000_0000, 1'b0, 30'h00AB_CFF0, 1'b0, 1'b0, 1'b0}, // R2
        '{32'h0000_1008, 1'b1, 32'h0000_0000, 1'b0, 30'h00AB_C008, 1'b1, 1'b0, 1'b0}, // R7
        '{32'h0000_1000, 1'b0, 32'h0000_0000, 1'b0, 30'h00AB_C000, 1'b1, 1'b0, 1'b0}, // R7
        '{32'h0000_2000, 1'b0, 32'h0000_0123, 1'b1, 30'h0000_0000, 1'b0, 1'b1, 1'b0}, // R5
        '{32'h0000_2004, 1'b0, 32'h8003_FFFF, 1'b1, 30'h3FFF_F004, 1'b0, 1'b0, 1'b0}, // R5
        '{32'h0000_3000, 1'b1, 32'hC000_0005, 1'b1, 30'h0000_5000, 1'b0, 1'b0, 1'b1}, // R6
        '{32'h0000_3010, 1'b0, 32'h0000_0000, 1'b0, 30'h0000_5010, 1'b0, 1'b0, 1'b0}, // R6
        '{32'h0000_3010, 1'b1, 32'h0000_0000, 1'b0, 30'h0000_5010, 1'b0, 1'b0, 1'b1}, // R6
        '{32'hFFFF_FABC, 1'b1, 32'h8000_0007, 1'b1, 30'h0000_7ABC, 1'b1, 1'b0, 1'b0}, // R7
        '{32'h0000_4000, 1'b0, 32'hA000_0009, 1'b1, 30'h0000_9000, 1'b1, 1'b0, 1'b0}  // R4
    };

    logic [31:0] base_m = 32'h0010_0000;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one translation; answers a page-table read with pte after lat cycles
    task automatic access(input logic [31:0] va, input logic st, input logic [31:0] pte,
                          input int lat, output logic miss, output logic [31:0] maddr,
                          output logic [29:0] pa, output logic dy, output logic fpg,
                          output logic fpr);
        miss = 1'b0; maddr = '0; pa = '0; dy = 1'b0; fpg = 1'b0; fpr = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_store = st;
        @(negedge clk);
        req_valid = 1'b0;
        if (!resp_valid) begin
            if (!mem_req_valid) begin
                chk("R3 read request after miss", 64'(mem_req_valid), 64'd1);
                return;
            end
            miss  = 1'b1;
            maddr = mem_req_addr;
            @(negedge clk);
            chk("R3 read request one cycle", 64'(mem_req_valid), 64'd0);
            chk("R3 ready low during refill", 64'(req_ready), 64'd0);
            for (int k = 0; k < lat; k++) @(negedge clk);
            mem_rsp_valid = 1'b1; mem_rsp_data = pte;
            @(negedge clk);
            mem_rsp_valid = 1'b0; mem_rsp_data = '0;
            chk("R4 response after PTE", 64'(resp_valid), 64'd1);
        end
        pa = resp_paddr; dy = resp_dirty; fpg = fault_page; fpr = fault_prot;
    endtask

    task automatic ctl(input logic we, input logic fl, input logic sup,
                       input logic [31:0] wd, output logic err);
        @(negedge clk);
        ctl_base_we = we; ctl_flush = fl; priv_sup = sup; ctl_base_wdata = wd;
        @(negedge clk);
        ctl_base_we = 1'b0; ctl_flush = 1'b0; priv_sup = 1'b0;
        err = priv_err;
    endtask

    task automatic expect_hit(input string tag, input logic [31:0] va, input logic exp_miss);
        logic m; logic [31:0] a; logic [29:0] p; logic d, f1, f2;
        access(va, 1'b0, 32'h8000_0001 | {14'd0, va[29:12]}, 1, m, a, p, d, f1, f2);
        chk(tag, 64'(m), 64'(exp_miss));
    endtask

    initial begin
        logic m, d, f1, f2, err;
        logic [31:0] a;
        logic [29:0] p;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 req_ready", 64'(req_ready), 64'd1);
        chk("R1 resp_valid", 64'(resp_valid), 64'd0);
        chk("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
        chk("R1 faults", 64'({fault_page, fault_prot, priv_err}), 64'd0);
        rst_n = 1'b1;

        ctl(1'b1, 1'b0, 1'b1, base_m, err);
        chk("R9 supervisor base write no error", 64'(err), 64'd0);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].va, VEC[i].st, VEC[i].pte, i % 3, m, a, p, d, f1, f2);
            chk($sformatf("R2 R3 vec%0d miss", i), 64'(m), 64'(VEC[i].miss));
            if (VEC[i].miss)
                chk($sformatf("R3 vec%0d pte address", i), 64'(a),
                    64'(base_m + {VEC[i].va[31:12], 2'b00}));
            chk($sformatf("R5 vec%0d page fault", i), 64'(f1), 64'(VEC[i].fpg));
            chk($sformatf("R6 vec%0d prot fault", i), 64'(f2), 64'(VEC[i].fpr));
            if (!VEC[i].fpg) begin
                chk($sformatf("R4 vec%0d paddr", i), 64'(p), 64'(VEC[i].pa));
                chk($sformatf("R7 vec%0d dirty", i), 64'(d), 64'(VEC[i].dy));
            end
        end

        // R8 replacement: entries 0..4 hold pages 1,2,3,FFFFF,4
        expect_hit("R8 fill page 10", 32'h0001_0000, 1'b1);
        expect_hit("R8 fill page 11", 32'h0001_1000, 1'b1);
        expect_hit("R8 fill page 12", 32'h0001_2000, 1'b1);
        expect_hit("R8 evict entry 0 for page 13", 32'h0001_3000, 1'b1);
        expect_hit("R8 page 2 kept", 32'h0000_2000, 1'b0);
        expect_hit("R8 page 1 evicted", 32'h0000_1000, 1'b1);
        expect_hit("R8 page 2 evicted next", 32'h0000_2000, 1'b1);
        expect_hit("R8 page 3 evicted next", 32'h0000_3000, 1'b1);
        expect_hit("R8 page 4 kept", 32'h0000_4000, 1'b0);
        expect_hit("R8 page 13 kept", 32'h0001_3000, 1'b0);

        // R10 flush privilege
        ctl(1'b0, 1'b1, 1'b0, '0, err);
        chk("R10 user flush error", 64'(err), 64'd1);
        expect_hit("R10 user flush ignored", 32'h0001_0000, 1'b0);
        ctl(1'b0, 1'b1, 1'b1, '0, err);
        chk("R10 supervisor flush no error", 64'(err), 64'd0);
        expect_hit("R10 flushed page misses", 32'h0001_0000, 1'b1);
        expect_hit("R10 other flushed page misses", 32'h0000_4000, 1'b1);

        // R9 base privilege
        ctl(1'b1, 1'b0, 1'b0, 32'h0020_0000, err);
        chk("R9 user base write error", 64'(err), 64'd1);
        access(32'h0003_0000, 1'b0, 32'h8000_0030, 2, m, a, p, d, f1, f2);
        chk("R9 base unchanged", 64'(a), 64'h0010_00C0);
        ctl(1'b1, 1'b0, 1'b1, 32'h0020_0000, err);
        chk("R9 supervisor base write", 64'(err), 64'd0);
        access(32'h0003_1000, 1'b0, 32'h8000_0031, 0, m, a, p, d, f1, f2);
        chk("R9 new base used", 64'(a), 64'h0020_00C4);

        // R11 stray memory response
        @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_data = 32'h8000_0111;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        chk("R11 no response from stray data", 64'(resp_valid), 64'd0);
        chk("R11 still ready", 64'(req_ready), 64'd1);
        access(32'h0002_0044, 1'b0, 32'h8000_0022, 1, m, a, p, d, f1, f2);
        chk("R11 page still misses", 64'(m), 64'd1);
        chk("R11 paddr from real PTE", 64'(p), 64'h0002_2044);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule